// File: doc/BRIEF.md
# Multiprocessor Receive Mute and Wakeup Gate

This block sits beside a serial receiver on a shared multi-drop line and decides which received frames and line events get through to software. It holds a mute state. While the node is muted, the per-frame and per-idle status strobes are held off, so the processor is not interrupted by traffic meant for other nodes. Software can set or clear the mute state at any time with a one-cycle write strobe.

Hardware can leave mute in one of two ways, chosen by a configuration bit. In idle-line wakeup (the default, `wake_addr = 0`), an idle-line event clears the mute state. In address wakeup (`wake_addr = 1`), a frame carrying an address tag is compared with the node's own short address. A match unmutes the node and delivers that frame. A mismatch mutes the node again. The tag bit sits at the top data bit of the frame. When parity is enabled it sits one bit lower, because the top bit then carries parity. The top data bit is bit 7 for 8-bit frames and bit 8 for 9-bit frames.

Every output is registered. A frame or idle strobe presented in cycle N shows its effect on the outputs in cycle N+1.

Top module: `mpcw_mute_gate`

## Requirements
- R1: While muted, a data frame (a frame that is not a wakeup frame) raises neither `rne_set` nor `perr_set`.
- R2: A pulse on `sw_wr` loads `sw_mute` into `muted`, and the new value is visible in the next cycle. After reset, `muted` is 0 and all strobes are 0.
- R3: With `wake_addr` = 0, an `idle_vld` pulse while muted clears `muted`, and `idle_set` stays 0 for that idle event.
- R4: An `idle_vld` pulse while not muted raises `idle_set` in the next cycle, in either wakeup mode.
- R5: With address wakeup and parity off, the address tag is bit 7 when `len9` = 0 and bit 8 when `len9` = 1. A tag of 1 marks an address frame and a tag of 0 marks a data frame.
- R6: With address wakeup and `par_en` = 1, the address tag is the bit one below the top data bit (bit 6 for 8-bit frames, bit 7 for 9-bit frames).
- R7: An address frame whose low 4 bits equal `node_addr` clears `muted`, raises `rne_set`, and loads the frame into `rx_data`.
- R8: An address frame whose low 4 bits differ from `node_addr` sets `muted`, and `rne_set` stays 0 for that frame.
- R9: A frame that is dropped while muted leaves `rx_data` unchanged. `rx_data` changes only together with `rne_set`.
- R10: When a software write and a hardware wakeup or re-mute fall in the same cycle, `muted` takes the software value. The gating of the frame in that cycle still follows the hardware rules.
- R11: `perr_set` is raised only for a delivered frame when `par_en` = 1 and `frame_perr` = 1. With parity off, parity is never reported.
- R12: With `wake_addr` = 1, an `idle_vld` pulse while muted neither unmutes the node nor raises `idle_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software write strobe for the mute state |
| sw_mute | input | 1 | Value written to the mute state |
| wake_addr | input | 1 | 0: idle-line wakeup, 1: address wakeup |
| par_en | input | 1 | Parity enabled in frames |
| len9 | input | 1 | 1: 9-bit frames, 0: 8-bit frames |
| node_addr | input | AW | Node address compared with the frame's low bits |
| frame_vld | input | 1 | Receiver frame-complete strobe |
| frame_data | input | DW | Received frame data word |
| frame_perr | input | 1 | Receiver parity error for this frame |
| idle_vld | input | 1 | Idle-line detect strobe |
| muted | output | 1 | Current mute state |
| rne_set | output | 1 | Gated receive-not-empty strobe |
| idle_set | output | 1 | Gated idle-line strobe |
| perr_set | output | 1 | Gated parity error strobe |
| rx_data | output | DW | Last delivered frame |

## Verification
The properties assume that the configuration inputs (`wake_addr`, `par_en`, `len9`, `node_addr`) stay steady in any cycle where a frame or idle strobe is present. They also assume that `frame_vld` and `idle_vld` are single-cycle pulses. The address-frame properties are written only for 8-bit frames with parity off, and they exclude cycles with a software write, so that they stay independent of the collision rule. The bench changes configuration only in cycles with no strobe. It pulses each strobe for exactly one cycle, and it places software writes on frame cycles only in the collision cases it deliberately sets up.

// File: rtl/mpcw_pkg.sv
package mpcw_pkg;
   typedef enum logic {
      WAKE_ON_IDLE = 1'b0,
      WAKE_ON_ADDR = 1'b1
   } wake_e;

   typedef struct packed {
      logic rne;
      logic idle;
      logic perr;
   } rx_evt_t;
endpackage

// File: rtl/mpcw_addr_decode.sv
module mpcw_addr_decode #(
   parameter int DW = 9,
   parameter int AW = 4
) (
   input  logic [DW-1:0] data,
   input  logic          par_en,
   input  logic          len9,
   input  logic [AW-1:0] node_addr,
   output logic          tag_bit,
   output logic          addr_hit
);
   localparam int IW = $clog2(DW);

   logic [IW-1:0] top_idx;
   logic [IW-1:0] tag_idx;

   generate
      if (DW < 8 || DW > 9) begin : g_bad_dw
         $error("mpcw_addr_decode: DW must be 8 or 9");
      end
      if (AW + 2 > DW) begin : g_bad_aw
         $error("mpcw_addr_decode: AW leaves no room for the tag bit");
      end
      if (DW > 8) begin : g_len_sel
         assign top_idx = len9 ? IW'(8) : IW'(7);
      end else begin : g_len_fix
         logic unused_len;
         assign unused_len = len9;
         assign top_idx = IW'(DW - 1);
      end
   endgenerate

   assign tag_idx  = par_en ? (top_idx - IW'(1)) : top_idx;
   assign tag_bit  = data[tag_idx];
   assign addr_hit = (data[AW-1:0] == node_addr);
endmodule

// File: rtl/mpcw_mute_reg.sv
module mpcw_mute_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_wr,
   input  logic sw_val,
   input  logic hw_set,
   input  logic hw_clr,
   output logic mute_q
);
   logic mute_d;

   always_comb begin
      mute_d = mute_q;
      if (hw_clr) mute_d = 1'b0;
      if (hw_set) mute_d = 1'b1;
      if (sw_wr)  mute_d = sw_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mute_q <= 1'b0;
      else        mute_q <= mute_d;
   end
endmodule

// File: rtl/mpcw_flag_gate.sv
module mpcw_flag_gate
   import mpcw_pkg::*;
#(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  wake_e         mode,
   input  logic          muted,
   input  logic          par_en,
   input  logic          frame_vld,
   input  logic [DW-1:0] frame_data,
   input  logic          frame_perr,
   input  logic          idle_vld,
   input  logic          tag_bit,
   input  logic          addr_hit,
   output logic          hw_set,
   output logic          hw_clr,
   output rx_evt_t       evt_q,
   output logic [DW-1:0] data_q
);
   logic    is_addr;
   logic    deliver;
   rx_evt_t evt_d;

   always_comb begin
      is_addr = (mode == WAKE_ON_ADDR) && frame_vld && tag_bit;
      deliver = frame_vld && (is_addr ? addr_hit : !muted);
      hw_clr  = ((mode == WAKE_ON_IDLE) && idle_vld && muted) || (is_addr && addr_hit);
      hw_set  = is_addr && !addr_hit;
      evt_d.rne  = deliver;
      evt_d.idle = idle_vld && !muted;
      evt_d.perr = deliver && par_en && frame_perr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q  <= '0;
         data_q <= '0;
      end else begin
         evt_q <= evt_d;
         if (deliver) data_q <= frame_data;
      end
   end
endmodule

// File: rtl/mpcw_mute_gate.sv
module mpcw_mute_gate
   import mpcw_pkg::*;
#(
   parameter int DW = 9,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_wr,
   input  logic          sw_mute,
   input  logic          wake_addr,
   input  logic          par_en,
   input  logic          len9,
   input  logic [AW-1:0] node_addr,
   input  logic          frame_vld,
   input  logic [DW-1:0] frame_data,
   input  logic          frame_perr,
   input  logic          idle_vld,
   output logic          muted,
   output logic          rne_set,
   output logic          idle_set,
   output logic          perr_set,
   output logic [DW-1:0] rx_data
);
   logic    tag_bit;
   logic    addr_hit;
   logic    hw_set;
   logic    hw_clr;
   rx_evt_t evt;
   wake_e   mode;

   assign mode = wake_e'(wake_addr);

   mpcw_addr_decode #(.DW(DW), .AW(AW)) u_dec (
      .data      (frame_data),
      .par_en    (par_en),
      .len9      (len9),
      .node_addr (node_addr),
      .tag_bit   (tag_bit),
      .addr_hit  (addr_hit)
   );

   mpcw_mute_reg u_mute (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_wr  (sw_wr),
      .sw_val (sw_mute),
      .hw_set (hw_set),
      .hw_clr (hw_clr),
      .mute_q (muted)
   );

   mpcw_flag_gate #(.DW(DW)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .muted      (muted),
      .par_en     (par_en),
      .frame_vld  (frame_vld),
      .frame_data (frame_data),
      .frame_perr (frame_perr),
      .idle_vld   (idle_vld),
      .tag_bit    (tag_bit),
      .addr_hit   (addr_hit),
      .hw_set     (hw_set),
      .hw_clr     (hw_clr),
      .evt_q      (evt),
      .data_q     (rx_data)
   );

   assign rne_set  = evt.rne;
   assign idle_set = evt.idle;
   assign perr_set = evt.perr;
endmodule

// File: rtl/mpcw_mute_gate_chk.sv
module mpcw_mute_gate_chk #(
   parameter int DW = 9,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sw_wr,
   input logic          sw_mute,
   input logic          wake_addr,
   input logic          par_en,
   input logic          len9,
   input logic [AW-1:0] node_addr,
   input logic          frame_vld,
   input logic [DW-1:0] frame_data,
   input logic          frame_perr,
   input logic          idle_vld,
   input logic          muted,
   input logic          rne_set,
   input logic          idle_set,
   input logic          perr_set,
   input logic [DW-1:0] rx_data
);
   logic unused_chk;
   assign unused_chk = frame_perr;

   AST_MUTED_DATA_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      muted && frame_vld && !wake_addr |=> !rne_set && !perr_set); // R1
   AST_SW_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr |=> (muted == $past(sw_mute))); // R2
   AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr && (idle_vld || frame_vld) |=> (muted == $past(sw_mute))); // R10
   AST_IDLE_WAKE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      muted && idle_vld && !wake_addr && !sw_wr |=> !muted && !idle_set); // R3
   AST_IDLE_FLAG_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      !muted && idle_vld |=> idle_set); // R4
   AST_ADDR_IDLE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      muted && idle_vld && wake_addr && !sw_wr |=> muted && !idle_set); // R12
   AST_ADDR_MATCH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_addr && !par_en && !len9 && frame_vld && frame_data[7]
      && (frame_data[AW-1:0] == node_addr) && !sw_wr |=> !muted && rne_set); // R7
   AST_ADDR_MISS_REMUTE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_addr && !par_en && !len9 && frame_vld && frame_data[7]
      && (frame_data[AW-1:0] != node_addr) && !sw_wr |=> muted && !rne_set); // R8
   AST_DATA_ONLY_ON_RNE: assert property (@(posedge clk) disable iff (!rst_n)
      !rne_set |-> $stable(rx_data)); // R9
   AST_PERR_NEEDS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      perr_set |-> rne_set && $past(par_en)); // R11
endmodule

bind mpcw_mute_gate mpcw_mute_gate_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_mpcw_mute_gate.sv
module sim_mpcw_mute_gate;
   localparam int CLK_T = 10;
   localparam int DW = 9;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_wr = 1'b0, sw_mute = 1'b0;
   logic          wake_addr = 1'b0, par_en = 1'b0, len9 = 1'b0;
   logic [AW-1:0] node_addr = 4'hA;
   logic          frame_vld = 1'b0, frame_perr = 1'b0, idle_vld = 1'b0;
   logic [DW-1:0] frame_data = '0;
   logic          muted, rne_set, idle_set, perr_set;
   logic [DW-1:0] rx_data;

   always #(CLK_T/2) clk = ~clk;

   mpcw_mute_gate #(.DW(DW), .AW(AW)) u0 (.*);

   typedef struct {
      logic          mute;
      logic          rne;
      logic          idle;
      logic          perr;
      logic [DW-1:0] data;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   int            checks = 0;
   int            errors = 0;
   bit            m_mute = 1'b0;
   logic [DW-1:0] m_data = '0;
   bit            done = 1'b0;

   // Expected outcome from the requirements, applied to one stimulus cycle.
   task automatic step(bit wr, bit wv, bit fv, logic [DW-1:0] d, bit pe, bit iv, string tag);
      int   top, tg;
      bit   isa, hit, ok, hwm;
      exp_t e;
      @(negedge clk);
      sw_wr = wr; sw_mute = wv; frame_vld = fv; frame_data = d;
      frame_perr = pe; idle_vld = iv;
      top = len9 ? 8 : 7;                       // R5
      tg  = par_en ? top - 1 : top;              // R6
      isa = wake_addr && fv && d[tg];
      hit = (d[3:0] == node_addr);
      ok  = fv && (isa ? hit : !m_mute);         // R7 R8 R9 R1
      hwm = m_mute;
      if (!wake_addr && iv && m_mute) hwm = 1'b0; // R3 R12
      if (isa) hwm = !hit;
      e.rne  = ok;
      e.idle = iv && !m_mute;                    // R4
      e.perr = ok && par_en && pe;               // R11
      e.data = ok ? d : m_data;
      e.mute = wr ? wv : hwm;                    // R2 R10
      e.tag  = tag;
      sb.push_back(e);
      m_mute = e.mute;
      m_data = e.data;
      @(posedge clk);
      #2;
      sw_wr = 1'b0; frame_vld = 1'b0; idle_vld = 1'b0; frame_perr = 1'b0;
   endtask

   task automatic cfg(bit wa, bit pe, bit l9);
      @(negedge clk);
      wake_addr = wa; par_en = pe; len9 = l9;
   endtask

   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (muted !== e.mute || rne_set !== e.rne || idle_set !== e.idle ||
             perr_set !== e.perr || rx_data !== e.data) begin
            errors++;
            $display("FAIL %s: got mute=%0b rne=%0b idle=%0b perr=%0b data=%h exp mute=%0b rne=%0b idle=%0b perr=%0b data=%h",
                     e.tag, muted, rne_set, idle_set, perr_set, rx_data,
                     e.mute, e.rne, e.idle, e.perr, e.data);
         end
      end
   end

   initial begin
      #(CLK_T * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hung run, exp completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (muted !== 1'b0 || rne_set !== 1'b0 || idle_set !== 1'b0 || perr_set !== 1'b0 || rx_data !== '0) begin
         errors++;
         $display("FAIL R2 reset: got mute=%0b rne=%0b idle=%0b perr=%0b data=%h exp all zero",
                  muted, rne_set, idle_set, perr_set, rx_data);
      end
      rst_n = 1'b1;

      // Idle-line wakeup mode
      step(0, 0, 1, 9'h035, 1, 0, "R11 open frame, parity off");
      step(0, 0, 0, 9'h000, 0, 1, "R4 idle while open");
      step(1, 1, 0, 9'h000, 0, 0, "R2 software mute");
      step(0, 0, 1, 9'h05C, 0, 0, "R9 muted frame dropped");
      step(0, 0, 1, 9'h08A, 1, 0, "R1 muted frame with error");
      step(0, 0, 0, 9'h000, 0, 1, "R3 idle wakes silently");
      step(1, 1, 0, 9'h000, 0, 0, "R2 mute again");
      step(1, 1, 0, 9'h000, 0, 1, "R10 idle wake vs software mute");
      step(1, 0, 0, 9'h000, 0, 0, "R2 software unmute");

      // Address wakeup, 8-bit, parity off
      cfg(1, 0, 0);
      step(1, 1, 0, 9'h000, 0, 0, "R2 mute for address mode");
      step(0, 0, 1, 9'h01A, 0, 0, "R9 data frame while muted");
      step(0, 0, 0, 9'h000, 0, 1, "R12 idle no wake in address mode");
      step(0, 0, 1, 9'h08A, 0, 0, "R7 R5 matching address wakes");
      step(0, 0, 1, 9'h033, 0, 0, "R5 data frame delivered while open");
      step(0, 0, 1, 9'h085, 0, 0, "R8 mismatch re-mutes");
      step(0, 0, 1, 9'h08A, 1, 0, "R11 match with error, parity off");
      step(1, 0, 1, 9'h085, 0, 0, "R10 mismatch vs software unmute");
      step(1, 1, 1, 9'h08A, 0, 0, "R10 match vs software mute");

      // Address wakeup, parity on: tag at bit 6
      cfg(1, 1, 0);
      step(0, 0, 1, 9'h08A, 0, 0, "R6 bit7 is parity, frame is data");
      step(0, 0, 1, 9'h04A, 1, 0, "R6 R11 tag bit6 match with error");
      step(0, 0, 1, 9'h045, 0, 0, "R6 tag bit6 mismatch");

      // Address wakeup, 9-bit, parity off: tag at bit 8
      cfg(1, 0, 1);
      step(0, 0, 1, 9'h08A, 0, 0, "R5 bit7 not tag for 9-bit");
      step(0, 0, 1, 9'h10A, 0, 0, "R5 bit8 tag match wakes");
      step(0, 0, 1, 9'h1F3, 0, 0, "R8 9-bit mismatch re-mutes");

      // 9-bit with parity: tag at bit 7
      cfg(1, 1, 1);
      step(0, 0, 1, 9'h08A, 1, 0, "R6 9-bit parity tag bit7 match");
      step(0, 0, 1, 9'h077, 1, 0, "R11 open data frame with error");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule